// File: doc/BRIEF.md
# Bit-Test and Decrement Branch Executor

This unit runs the conditional branches of a small 8-bit controller core that branch on one bit of an operand, and the loop instruction that decrements a byte and branches while the byte is not zero. The core's decoder hands over an opcode class, an operand kind, a bit index, a signed 8-bit displacement and the address of the instruction. It also supplies the operand byte it has already read and a flag that tells whether that byte lives in fast internal RAM. The unit starts on a one-cycle `start`. It then stays busy for the cycle count that the instruction class and the operand's location call for. At the end it raises `done` for one cycle, and in that cycle it presents the next program counter, the taken flag and any byte that must be written back.

The branch target is measured from the end of the instruction, so it depends on the instruction length. The length varies with the opcode class and the operand kind. Writing back the status-word byte is the only way a flag in this group ever changes.

Top module: `bitbranch_exec`

## Requirements
- R1: Opcode classes on `op` are 0 = branch if bit set, 1 = branch if bit clear, 2 = branch if bit set then clear it, 3 = decrement and branch if nonzero. Operand kinds on `src` are 0 = short direct RAM, 1 = special register, 2 = accumulator, 3 = status word, 4 = indirect through pair, 5 = register B, 6 = register C. For class 3, kinds 5 and 6 are the register forms and every other kind is the RAM form.
- R2: The instruction length is set as follows. Class 3 is 2 bytes in register form and 3 bytes in RAM form. Classes 0 to 2 are 4 bytes on a special register. On the status word they are 3 bytes for class 0 and 4 bytes for classes 1 and 2. In every other case the length is 3 bytes.
- R3: `next_pc` is `pc` + length + the sign-extended `disp` when the branch is taken, and `pc` + length when it is not. The sum wraps modulo 2^16.
- R4: The unit reads bit `bit_sel` (0 = LSB) of `opnd`. Class 0 is taken when that bit is 1 and class 1 is taken when it is 0.
- R5: Class 2 is taken when the bit is 1. In that case it writes back `opnd` with only that bit cleared. When the bit is 0 it writes nothing.
- R6: Class 3 always writes back `opnd` - 1. An operand of 0x00 becomes 0xFF. The branch is taken when the written value is not zero.
- R7: The cycle counts, from the start cycle up to and including the done cycle, are as follows. Classes 0 to 2 take 8 on the accumulator and 11 on a special register, or 12 for class 2. On the status word they take 9, 11 and 12 for classes 0, 1 and 2. On short RAM they take 8, or 10 for class 2, when `fast_ram`=1, and 9, 9 and 11 otherwise. On indirect they take 10 when `fast_ram`=1, and otherwise 11, or 12 for class 2. Class 3 takes 6 in register form, and 8 in RAM form when `fast_ram`=1 or 10 otherwise. A branch that is not taken takes the same count.
- R8: `done` is a single-cycle pulse, and `next_pc`, `taken`, `wr_en` and `wr_data` are valid in that cycle. `start` has no effect while `busy` is high.
- R9: `wr_en` is high only in a done cycle, and only for class 3 or for a taken class 2.
- R10: After reset, `busy`, `done`, `taken` and `wr_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (ignored while busy) |
| op | input | 2 | Opcode class |
| src | input | 3 | Operand kind |
| bit_sel | input | 3 | Bit index within the operand |
| disp | input | 8 | Signed branch displacement |
| pc | input | 16 | Address of the instruction's first byte |
| fast_ram | input | 1 | Operand lies in fast internal RAM |
| opnd | input | 8 | Operand byte |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken (valid with done) |
| next_pc | output | 16 | Next program counter (valid with done) |
| wr_en | output | 1 | Write back wr_data to the operand |
| wr_data | output | 8 | Byte to write back |

## Verification
The bench covers several corner cases, and for each one a specific error would show up. It decrements 0x00 and 0x01: a design that tested the value before the decrement would take the wrong path on both. It uses negative displacements and a PC near 0xFFFF: a sign or wrap error would show up in `next_pc`. It runs the status-word and special-register forms, whose lengths and counts differ from the common case, together with not-taken class 2 instructions, where a careless design would still write. It also pulses `start` during a busy period; a design that restarted there would move the done pulse.

// File: rtl/bitbranch_exec.sv
module bitbranch_exec #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic [2:0]      src,
  input  logic [2:0]      bit_sel,
  input  logic [7:0]      disp,
  input  logic [PC_W-1:0] pc,
  input  logic            fast_ram,
  input  logic [7:0]      opnd,
  output logic            busy,
  output logic            done,
  output logic            taken,
  output logic [PC_W-1:0] next_pc,
  output logic            wr_en,
  output logic [7:0]      wr_data
);
  localparam logic [1:0] OP_SET = 2'd0, OP_CLR = 2'd1, OP_SETCLR = 2'd2, OP_DEC = 2'd3;
  localparam logic [2:0] K_RAM = 3'd0, K_SFR = 3'd1, K_ACC = 3'd2, K_PSW = 3'd3,
                         K_IND = 3'd4, K_RB = 3'd5, K_RC = 3'd6;

  logic             is_dec, dec_reg, bitv, tk, wen;
  logic [7:0]       dec_val, wdata;
  logic [2:0]       len;
  logic [CNT_W-1:0] cyc, cnt;
  logic             wen_q;
  logic [1:0]       op_q;

  assign is_dec  = (op == OP_DEC);
  assign dec_reg = (src == K_RB) || (src == K_RC);
  assign bitv    = opnd[bit_sel];
  assign dec_val = opnd - 8'd1;
  assign tk      = is_dec ? (dec_val != 8'd0) : ((op == OP_CLR) ? ~bitv : bitv);
  assign wen     = is_dec || ((op == OP_SETCLR) && bitv);
  assign wdata   = is_dec ? dec_val : (opnd & ~(8'd1 << bit_sel));

  always_comb begin
    if (is_dec)              len = dec_reg ? 3'd2 : 3'd3;
    else if (src == K_SFR)   len = 3'd4;
    else if (src == K_PSW)   len = (op == OP_SET) ? 3'd3 : 3'd4;
    else                     len = 3'd3;
  end

  always_comb begin
    cyc = CNT_W'(8);
    if (is_dec) begin
      if (dec_reg)       cyc = CNT_W'(6);
      else if (fast_ram) cyc = CNT_W'(8);
      else               cyc = CNT_W'(10);
    end else begin
      case (src)
        K_ACC: cyc = CNT_W'(8);
        K_SFR: cyc = (op == OP_SETCLR) ? CNT_W'(12) : CNT_W'(11);
        K_PSW: cyc = (op == OP_SET) ? CNT_W'(9) : (op == OP_CLR) ? CNT_W'(11) : CNT_W'(12);
        K_IND: cyc = fast_ram ? CNT_W'(10) : ((op == OP_SETCLR) ? CNT_W'(12) : CNT_W'(11));
        default: begin
          if (fast_ram) cyc = (op == OP_SETCLR) ? CNT_W'(10) : CNT_W'(8);
          else          cyc = (op == OP_SETCLR) ? CNT_W'(11) : CNT_W'(9);
        end
      endcase
    end
  end

  assign done  = busy && (cnt == '0);
  assign wr_en = done && wen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      taken   <= 1'b0;
      next_pc <= '0;
      wen_q   <= 1'b0;
      wr_data <= '0;
      op_q    <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        cnt     <= cyc - CNT_W'(2);
        taken   <= tk;
        next_pc <= pc + PC_W'(len) + (tk ? {{(PC_W-8){disp[7]}}, disp} : '0);
        wen_q   <= wen;
        wr_data <= wdata;
        op_q    <= op;
      end
    end else if (done) begin
      busy  <= 1'b0;
      taken <= 1'b0;
      wen_q <= 1'b0;
    end else begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy);
  p_wr_in_done_r9: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> done);
  p_clr_on_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op_q == OP_SETCLR) |-> taken);
  p_dec_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_DEC) |-> (wr_en && (taken == (wr_data != 8'd0))));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!done && !wr_en));
endmodule

// File: tb/bitbranch_exec_bench.sv
module bitbranch_exec_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, fast_ram = 1'b0;
  logic [1:0] op = '0;
  logic [2:0] src = '0, bit_sel = '0;
  logic [7:0] disp = '0, opnd = '0;
  logic [15:0] pc = '0;
  logic busy, done, taken, wr_en;
  logic [15:0] next_pc;
  logic [7:0] wr_data;

  int checks = 0, errors = 0;

  bitbranch_exec u_bitbranch_exec (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src(src), .bit_sel(bit_sel),
    .disp(disp), .pc(pc), .fast_ram(fast_ram), .opnd(opnd), .busy(busy), .done(done),
    .taken(taken), .next_pc(next_pc), .wr_en(wr_en), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  bit m_busy = 0;
  int m_rem = 0;
  bit m_taken = 0, m_wen = 0;
  int m_npc = 0, m_wdata = 0;

  function automatic int ref_len(int o, int s);
    if (o == 3) return (s == 5 || s == 6) ? 2 : 3;
    if (s == 1) return 4;
    if (s == 3) return (o == 0) ? 3 : 4;
    return 3;
  endfunction

  function automatic int ref_cyc(int o, int s, bit f);
    if (o == 3) begin
      if (s == 5 || s == 6) return 6;
      return f ? 8 : 10;
    end
    if (s == 2) return 8;
    if (s == 1) return (o == 2) ? 12 : 11;
    if (s == 3) return (o == 0) ? 9 : (o == 1 ? 11 : 12);
    if (s == 4) return f ? 10 : (o == 2 ? 12 : 11);
    if (f) return (o == 2) ? 10 : 8;
    return (o == 2) ? 11 : 9;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_busy = 0;
    else if (!m_busy) begin
      if (start) begin
        int b, nv, d;
        b = (opnd >> bit_sel) & 1;
        d = (disp > 127) ? int'(disp) - 256 : int'(disp);
        m_wen = 0;
        if (op == 3) begin
          nv = (opnd + 255) % 256;
          m_taken = (nv != 0); m_wen = 1; m_wdata = nv;
        end else begin
          m_taken = (op == 1) ? (b == 0) : (b == 1);
          if (op == 2 && b == 1) begin m_wen = 1; m_wdata = opnd - (1 << bit_sel); end
        end
        m_npc = (pc + ref_len(op, src) + (m_taken ? d : 0) + 65536) % 65536;
        m_rem = ref_cyc(op, src, fast_ram) - 1;
        m_busy = 1;
      end
    end else if (m_rem == 1) m_busy = 0;
    else m_rem--;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ed;
      ed = m_busy && (m_rem == 1);
      chk(done == ed, "R7", "done", done, ed);
      chk(busy == m_busy, "R8", "busy", busy, m_busy);
      if (!ed) chk(wr_en == 0, "R9", "wr_en outside done", wr_en, 0);
      if (ed && done) begin
        chk(taken == m_taken, "R4", "taken", taken, m_taken);
        chk(next_pc == m_npc[15:0], "R3", "next_pc", next_pc, m_npc);
        chk(wr_en == m_wen, "R9", "wr_en", wr_en, m_wen);
        if (m_wen) chk(wr_data == m_wdata[7:0], "R5", "wr_data", wr_data, m_wdata);
      end
    end
  end

  task automatic run(int o, int s, int b, int d, int p, bit f, int v);
    @(negedge clk);
    op = 2'(o); src = 3'(s); bit_sel = 3'(b); disp = 8'(d); pc = 16'(p);
    fast_ram = f; opnd = 8'(v); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && taken == 0 && wr_en == 0, "R10", "reset outputs",
        {busy, done, taken, wr_en}, 0);
    rst_n = 1'b1;
    // R1 R4: set/clear tests on several kinds
    run(0, 0, 3, 8'h10, 16'h1000, 1, 8'h08);   // taken
    run(0, 0, 3, 8'h10, 16'h1000, 0, 8'h00);   // not taken, slow
    run(1, 2, 7, 8'hF0, 16'h2000, 1, 8'h7F);   // taken, negative disp
    run(1, 1, 0, 8'h05, 16'h2100, 1, 8'h01);   // sfr not taken
    run(0, 3, 6, 8'h20, 16'h3000, 1, 8'h40);   // R2 status word len 3
    run(1, 3, 6, 8'h20, 16'h3000, 1, 8'h00);   // len 4
    run(1, 4, 2, 8'h80, 16'h0050, 1, 8'h00);   // R3 wrap below zero
    run(0, 4, 2, 8'h01, 16'hFFFE, 0, 8'h04);   // R3 wrap above 0xFFFF
    // R5: set-then-clear
    run(2, 0, 5, 8'h03, 16'h4000, 1, 8'hFF);
    run(2, 0, 5, 8'h03, 16'h4000, 0, 8'hDF);   // not taken, no write
    run(2, 3, 0, 8'h10, 16'h4100, 1, 8'h81);   // status word flag clear
    run(2, 1, 7, 8'hFE, 16'h4200, 1, 8'h80);
    run(2, 4, 1, 8'h02, 16'h4300, 0, 8'h02);
    run(2, 2, 4, 8'h02, 16'h4400, 1, 8'h00);
    // R6: decrement forms
    run(3, 5, 0, 8'hFC, 16'h5000, 1, 8'h05);
    run(3, 6, 0, 8'hFC, 16'h5000, 1, 8'h01);   // reaches zero: not taken
    run(3, 0, 0, 8'hFC, 16'h5000, 1, 8'h00);   // wraps to FF: taken
    run(3, 2, 0, 8'h7F, 16'h5100, 0, 8'h10);   // RAM form, slow
    // R8: start while busy is ignored
    @(negedge clk);
    op = 2'd1; src = 3'd1; bit_sel = 3'd0; disp = 8'h01; pc = 16'h6000; fast_ram = 1; opnd = 8'h00;
    start = 1'b1;
    @(negedge clk);
    op = 2'd3; src = 3'd5; opnd = 8'h09;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R8", "idle after ignored start", busy, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule